// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals of an incremental rotary or linear encoder, plus its once-per-turn index signal, into a signed-free 16-bit position count. The three pins arrive asynchronously. They are brought into the clock domain, and rising, falling or both edges are picked out per input. One of three counting rules is then applied: separate up and down pulses, quadrature phase order, or step-plus-direction.

The index pin has two uses. It can reset the count to zero on a chosen edge, or it can act as a level gate that lets counting through only while the pin is at a chosen level. The count runs between zero and a programmable ceiling. Going past the ceiling wraps to zero, and going below zero reloads the ceiling. Each wrap raises a one-cycle pulse for a downstream revolution counter, along with a direction bit.

A stop control freezes counting. While the counter is stopped, software may load a new count through a simple write strobe.

Top module: `qpos_counter`

## Requirements
- R1: After reset, `position` is 0, `ovfPulse`, `unfPulse` and `wrapDir` are 0, and `lastDirValid` is 0.
- R2: With `countMode` = 01, an active A edge adds one and an active B edge subtracts one. When active A and B edges are seen in the same cycle, the count does not change.
- R3: With `countMode` = 10, every active A or B edge moves the count by one. The count rises when A leads B: an A edge counts up if A differs from B after the edge, and a B edge counts up if B equals A after the edge. Simultaneous A and B edges leave the count unchanged.
- R4: With `countMode` = 11, only active B edges count. The count goes up when the synchronised A level is 1 and down when it is 0. With `countMode` = 00, nothing counts.
- R5: `aEdgeSel` and `bEdgeSel` each choose the active edge of their input: 00 none, 01 falling, 10 rising, 11 both. These selections apply in every counting mode.
- R6: When `swapAB` is 1, pin A feeds the B input and pin B feeds the A input, so a forward quadrature pattern counts down.
- R7: With `zGateMode` = 0, a Z edge selected by `zSel` (00 none, 01 falling, 10 rising, 11 both) clears the count to 0. This happens in any mode, even while the counter is stopped. A clear beats a count step or a write in the same cycle.
- R8: With `zGateMode` = 1, `zSel` = 01 lets counting through only while Z is low, and 10 only while Z is high. The values 00 and 11 disable the gate, so counting is always allowed.
- R9: An up step taken when `position` is greater than or equal to `maxPos` loads 0. In the same cycle as that load, `ovfPulse` and `wrapDir` are 1 for one cycle.
- R10: A down step taken when `position` is 0 loads `maxPos`. In the same cycle as that load, `unfPulse` is 1 for one cycle and `wrapDir` is 0.
- R11: While `stopCount` is 1, no step is applied, and `wrEn` loads `wrData` on the next edge. A write while `stopCount` is 0 is ignored.
- R12: Every applied step sets `lastDir` to its direction (1 = up) and sets `lastDirValid`. While `countMode` is 00, `lastDirValid` is cleared.
- R13: A pin change becomes visible at the outputs after the third rising clock edge that follows it: two synchroniser stages and one count register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinA | input | 1 | Encoder phase A, asynchronous |
| pinB | input | 1 | Encoder phase B, asynchronous |
| pinZ | input | 1 | Encoder index, asynchronous |
| countMode | input | 2 | 00 off, 01 up/down, 10 phase, 11 step/direction |
| swapAB | input | 1 | Exchange the A and B pins |
| aEdgeSel | input | 2 | Active edge of A |
| bEdgeSel | input | 2 | Active edge of B |
| zGateMode | input | 1 | 0: Z clears the count, 1: Z gates counting |
| zSel | input | 2 | Z edge (clear mode) or Z level (gate mode) |
| stopCount | input | 1 | Freeze counting and enable writes |
| maxPos | input | 16 | Wrap ceiling |
| wrEn | input | 1 | Write strobe |
| wrData | input | 16 | Value to load |
| position | output | 16 | Current count |
| ovfPulse | output | 1 | One-cycle pulse on wrap past the ceiling |
| unfPulse | output | 1 | One-cycle pulse on wrap below zero |
| wrapDir | output | 1 | 1 together with overflow, 0 otherwise |
| lastDir | output | 1 | Direction of the latest applied step |
| lastDirValid | output | 1 | `lastDir` is meaningful |

## Verification
The bench targets a Z clear edge that arrives in the same cycle as a phase step. A design that lets the step win would end one count off zero. It drives simultaneous A and B edges in up/down mode, where a design without the cancel rule would drift. It crosses the ceiling in both directions with a small `maxPos`: an off-by-one compare would wrap one step late, and a wrong reload would land on zero instead of the ceiling. It also checks swapped pins, gate levels, writes attempted while running, and the loss of direction validity in the off mode, and it compares the outputs with a timed behavioural model on every clock to catch a wrong pipeline depth.

// File: rtl/qpos_pkg.sv
package qpos_pkg;

  typedef enum logic [1:0] {
    CNT_OFF   = 2'b00,
    CNT_UPDN  = 2'b01,
    CNT_PHASE = 2'b10,
    CNT_DIR   = 2'b11
  } cntMode_e;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic clear;      // Z clear edge
    logic load;       // accepted write
    logic step;       // count step allowed
    logic stepUp;     // direction of step
    logic dirForget;  // direction indication invalid
  } qposStrobe_t;

  function automatic logic edgeHit(input logic [1:0] sel, input logic nowVal,
                                   input logic prevVal);
    logic hit;
    case (sel)
      2'b01:   hit = prevVal & ~nowVal;
      2'b10:   hit = ~prevVal & nowVal;
      2'b11:   hit = prevVal ^ nowVal;
      default: hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/qpos_sync.sv
module qpos_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= din;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= stage[g-1];
      end
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/qpos_ctrl.sv
module qpos_ctrl
  import qpos_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pinA,
  input  logic        pinB,
  input  logic        pinZ,
  input  logic        swapAB,
  input  logic [1:0]  countMode,
  input  logic [1:0]  aEdgeSel,
  input  logic [1:0]  bEdgeSel,
  input  logic        zGateMode,
  input  logic [1:0]  zSel,
  input  logic        stopCount,
  input  logic        wrEn,
  output qposStrobe_t strobe
);
  localparam int NUM_IN = 3;  // [0] A, [1] B, [2] Z
  localparam int IDX_A  = 0;
  localparam int IDX_B  = 1;
  localparam int IDX_Z  = 2;

  logic [NUM_IN-1:0] routed, syncNow, syncPrev;
  logic aHit, bHit, zHit;
  logic evt, up, gateOpen;

  assign routed = swapAB ? {pinZ, pinA, pinB} : {pinZ, pinB, pinA};

  qpos_sync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_IN)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (routed),
    .dout (syncNow)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPrev <= '0;
    else       syncPrev <= syncNow;
  end

  assign aHit = edgeHit(aEdgeSel, syncNow[IDX_A], syncPrev[IDX_A]);
  assign bHit = edgeHit(bEdgeSel, syncNow[IDX_B], syncPrev[IDX_B]);
  assign zHit = edgeHit(zSel,     syncNow[IDX_Z], syncPrev[IDX_Z]);

  always_comb begin
    evt = 1'b0;
    up  = 1'b0;
    case (cntMode_e'(countMode))
      CNT_UPDN: begin
        evt = aHit ^ bHit;
        up  = aHit;
      end
      CNT_PHASE: begin
        evt = aHit ^ bHit;
        up  = aHit ? (syncNow[IDX_A] ^ syncNow[IDX_B])
                   : (syncNow[IDX_A] ~^ syncNow[IDX_B]);
      end
      CNT_DIR: begin
        evt = bHit;
        up  = syncNow[IDX_A];
      end
      default: ;
    endcase
  end

  always_comb begin
    gateOpen = 1'b1;
    if (zGateMode) begin
      case (zSel)
        2'b01:   gateOpen = ~syncNow[IDX_Z];
        2'b10:   gateOpen = syncNow[IDX_Z];
        default: gateOpen = 1'b1;
      endcase
    end
  end

  assign strobe.clear     = ~zGateMode & zHit;
  assign strobe.load      = wrEn & stopCount;
  assign strobe.step      = evt & gateOpen & ~stopCount;
  assign strobe.stepUp    = up;
  assign strobe.dirForget = (cntMode_e'(countMode) == CNT_OFF);
endmodule

// File: rtl/qpos_dpath.sv
module qpos_dpath
  import qpos_pkg::*;
#(
  parameter int W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  qposStrobe_t strobe,
  input  logic [W-1:0] maxPos,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] position,
  output logic        ovfPulse,
  output logic        unfPulse,
  output logic        wrapDir,
  output logic        lastDir,
  output logic        lastDirValid
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] posNext;
  logic ovfNext, unfNext, stepApplied;

  assign stepApplied = strobe.step & ~strobe.clear;

  always_comb begin
    posNext = position;
    ovfNext = 1'b0;
    unfNext = 1'b0;
    if (strobe.clear) begin
      posNext = '0;
    end else if (strobe.load) begin
      posNext = wrData;
    end else if (strobe.step) begin
      if (strobe.stepUp) begin
        if (position >= maxPos) begin
          posNext = '0;
          ovfNext = 1'b1;
        end else begin
          posNext = position + ONE;
        end
      end else begin
        if (position == '0) begin
          posNext = maxPos;
          unfNext = 1'b1;
        end else begin
          posNext = position - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      position     <= '0;
      ovfPulse     <= 1'b0;
      unfPulse     <= 1'b0;
      wrapDir      <= 1'b0;
      lastDir      <= 1'b0;
      lastDirValid <= 1'b0;
    end else begin
      position <= posNext;
      ovfPulse <= ovfNext;
      unfPulse <= unfNext;
      wrapDir  <= ovfNext;
      if (stepApplied) lastDir <= strobe.stepUp;
      if (strobe.dirForget)  lastDirValid <= 1'b0;
      else if (stepApplied)  lastDirValid <= 1'b1;
    end
  end
endmodule

// File: rtl/qpos_counter.sv
module qpos_counter
  import qpos_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         pinA,
  input  logic         pinB,
  input  logic         pinZ,
  input  logic [1:0]   countMode,
  input  logic         swapAB,
  input  logic [1:0]   aEdgeSel,
  input  logic [1:0]   bEdgeSel,
  input  logic         zGateMode,
  input  logic [1:0]   zSel,
  input  logic         stopCount,
  input  logic [W-1:0] maxPos,
  input  logic         wrEn,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] position,
  output logic         ovfPulse,
  output logic         unfPulse,
  output logic         wrapDir,
  output logic         lastDir,
  output logic         lastDirValid
);
  qposStrobe_t strobe;

  qpos_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .pinA      (pinA),
    .pinB      (pinB),
    .pinZ      (pinZ),
    .swapAB    (swapAB),
    .countMode (countMode),
    .aEdgeSel  (aEdgeSel),
    .bEdgeSel  (bEdgeSel),
    .zGateMode (zGateMode),
    .zSel      (zSel),
    .stopCount (stopCount),
    .wrEn      (wrEn),
    .strobe    (strobe)
  );

  qpos_dpath #(.W(W)) uDpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .maxPos       (maxPos),
    .wrData       (wrData),
    .position     (position),
    .ovfPulse     (ovfPulse),
    .unfPulse     (unfPulse),
    .wrapDir      (wrapDir),
    .lastDir      (lastDir),
    .lastDirValid (lastDirValid)
  );
endmodule

// File: rtl/qpos_checker.sv
module qpos_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic [1:0]   countMode,
  input logic         zGateMode,
  input logic         stopCount,
  input logic [W-1:0] maxPos,
  input logic         wrEn,
  input logic [W-1:0] wrData,
  input logic [W-1:0] position,
  input logic         ovfPulse,
  input logic         unfPulse,
  input logic         wrapDir,
  input logic         lastDirValid
);
  // R9
  ovf_lands_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> (position == '0) && wrapDir);

  // R10
  unf_lands_max_chk: assert property (@(posedge clk) disable iff (!rstN)
    unfPulse |-> (position == $past(maxPos)) && !wrapDir);

  // R9 R10
  wrap_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ovfPulse && unfPulse));

  // R11
  stopped_no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopCount |=> !ovfPulse && !unfPulse);

  // R11
  write_loads_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && stopCount && zGateMode) |=> position == $past(wrData));

  // R12
  off_forgets_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    (countMode == 2'b00) |=> !lastDirValid);
endmodule

bind qpos_counter qpos_checker #(.W(W)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .countMode    (countMode),
  .zGateMode    (zGateMode),
  .stopCount    (stopCount),
  .maxPos       (maxPos),
  .wrEn         (wrEn),
  .wrData       (wrData),
  .position     (position),
  .ovfPulse     (ovfPulse),
  .unfPulse     (unfPulse),
  .wrapDir      (wrapDir),
  .lastDirValid (lastDirValid)
);

// File: tb/test_qpos_counter.sv
`timescale 1ns/1ps
module test_qpos_counter;
  localparam int W    = 16;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinA = 0, pinB = 0, pinZ = 0;
  logic [1:0] countMode = 0, aEdgeSel = 0, bEdgeSel = 0, zSel = 0;
  logic swapAB = 0, zGateMode = 0, stopCount = 0, wrEn = 0;
  logic [W-1:0] maxPos = '1, wrData = '0;
  logic [W-1:0] position;
  logic ovfPulse, unfPulse, wrapDir, lastDir, lastDirValid;

  int tests = 0, failed = 0;
  bit sawOvf = 0, sawUnf = 0, running = 0;

  always #2 clk = ~clk;

  qpos_counter #(.W(W)) i_qpos_counter (
    .clk(clk), .rstN(rstN), .pinA(pinA), .pinB(pinB), .pinZ(pinZ),
    .countMode(countMode), .swapAB(swapAB), .aEdgeSel(aEdgeSel),
    .bEdgeSel(bEdgeSel), .zGateMode(zGateMode), .zSel(zSel),
    .stopCount(stopCount), .maxPos(maxPos), .wrEn(wrEn), .wrData(wrData),
    .position(position), .ovfPulse(ovfPulse), .unfPulse(unfPulse),
    .wrapDir(wrapDir), .lastDir(lastDir), .lastDirValid(lastDirValid));

  // ---------------- behavioural reference ----------------
  bit [2:0] hist[$];        // {z,b,a} as sampled at each past edge
  int  mPos;
  bit  mOvf, mUnf, mLd, mLdv;

  function automatic bit selHit(int sel, bit nowV, bit prevV);
    if (sel == 1) return prevV && !nowV;
    if (sel == 2) return !prevV && nowV;
    if (sel == 3) return prevV != nowV;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      hist = {3'b000, 3'b000, 3'b000};
      mPos = 0; mOvf = 0; mUnf = 0; mLd = 0; mLdv = 0;
    end else begin
      bit [2:0] cur, prv;
      bit ha, hb, hz, move, dirUp, gate;
      cur = hist[hist.size()-2];
      prv = hist[hist.size()-3];
      ha = selHit(aEdgeSel, cur[0], prv[0]);
      hb = selHit(bEdgeSel, cur[1], prv[1]);
      hz = selHit(zSel, cur[2], prv[2]);
      move = 0; dirUp = 0;
      if (countMode == 1) begin move = ha != hb; dirUp = ha; end
      if (countMode == 2) begin
        move = ha != hb;
        dirUp = ha ? (cur[0] != cur[1]) : (cur[0] == cur[1]);
      end
      if (countMode == 3) begin move = hb; dirUp = cur[0]; end
      gate = 1;
      if (zGateMode && zSel == 1) gate = !cur[2];
      if (zGateMode && zSel == 2) gate = cur[2];
      if (stopCount || !gate) move = 0;
      mOvf = 0; mUnf = 0;
      if (!zGateMode && hz) mPos = 0;
      else if (stopCount && wrEn) mPos = wrData;
      else if (move) begin
        mLd = dirUp; mLdv = 1;
        if (dirUp) begin
          if (mPos >= maxPos) begin mPos = 0; mOvf = 1; end else mPos++;
        end else begin
          if (mPos == 0) begin mPos = maxPos; mUnf = 1; end else mPos--;
        end
      end
      if (countMode == 0) mLdv = 0;
      hist.push_back({pinZ, swapAB ? pinA : pinB, swapAB ? pinB : pinA});
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  task automatic checkEq(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R13: compare against the reference on every clock
  always @(negedge clk) begin
    if (running) begin
      if (ovfPulse) sawOvf = 1;
      if (unfPulse) sawUnf = 1;
      tests++;
      if (position != W'(mPos) || ovfPulse != mOvf || unfPulse != mUnf ||
          wrapDir != mOvf || lastDirValid != mLdv || (mLdv && lastDir != mLd)) begin
        failed++;
        $display("FAIL R13: actual pos=%0d ovf=%0b unf=%0b wd=%0b ld=%0b ldv=%0b expected pos=%0d ovf=%0b unf=%0b wd=%0b ld=%0b ldv=%0b",
                 position, ovfPulse, unfPulse, wrapDir, lastDir, lastDirValid,
                 mPos, mOvf, mUnf, mOvf, mLd, mLdv);
      end
    end
  end

  task automatic setPins(bit a, bit b, bit z);
    @(negedge clk);
    pinA = a; pinB = b; pinZ = z;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic fwdCycle(bit z);
    setPins(1, 0, z); setPins(1, 1, z); setPins(0, 1, z); setPins(0, 0, z);
  endtask

  task automatic bwdCycle(bit z);
    setPins(0, 1, z); setPins(1, 1, z); setPins(1, 0, z); setPins(0, 0, z);
  endtask

  task automatic settle();
    repeat (HOLD) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1; running = 1;
    @(negedge clk);
    // R1 reset state
    checkEq("R1 position", position, 0);
    checkEq("R1 pulses", {ovfPulse, unfPulse, wrapDir}, 0);
    checkEq("R1 lastDirValid", lastDirValid, 0);

    // R2 up/down mode, rising edges
    countMode = 2'b01; aEdgeSel = 2'b10; bEdgeSel = 2'b10;
    repeat (3) begin setPins(1, 0, 0); setPins(0, 0, 0); end
    setPins(0, 1, 0); setPins(0, 0, 0);
    checkEq("R2 up then down", position, 2);
    setPins(1, 1, 0); setPins(0, 0, 0);
    checkEq("R2 simultaneous edges", position, 2);

    // R3 phase mode, all edges
    countMode = 2'b10; aEdgeSel = 2'b11; bEdgeSel = 2'b11;
    fwdCycle(0); fwdCycle(0);
    checkEq("R3 forward", position, 10);
    bwdCycle(0);
    checkEq("R3 backward", position, 6);
    checkEq("R12 lastDir down", {lastDirValid, lastDir}, 2);

    // R5 edge selection
    aEdgeSel = 2'b10; bEdgeSel = 2'b00;
    fwdCycle(0);
    checkEq("R5 A rising only", position, 7);
    aEdgeSel = 2'b00;
    fwdCycle(0);
    checkEq("R5 no edges", position, 7);

    // R4 step/direction mode
    countMode = 2'b11; bEdgeSel = 2'b10;
    setPins(1, 0, 0);
    setPins(1, 1, 0); setPins(1, 0, 0); setPins(1, 1, 0); setPins(1, 0, 0);
    setPins(0, 0, 0);
    setPins(0, 1, 0); setPins(0, 0, 0);
    checkEq("R4 direction from A", position, 8);
    countMode = 2'b00;
    setPins(1, 0, 0); setPins(1, 1, 0); setPins(1, 0, 0); setPins(0, 0, 0);
    checkEq("R4 off mode", position, 8);
    checkEq("R12 valid cleared", lastDirValid, 0);

    // R6 swap
    swapAB = 1; settle();
    countMode = 2'b10; aEdgeSel = 2'b11; bEdgeSel = 2'b11;
    fwdCycle(0);
    checkEq("R6 swapped", position, 4);
    countMode = 2'b00; settle(); swapAB = 0; settle();

    // R9 / R10 wrap
    stopCount = 1; wrEn = 1; wrData = 3; @(negedge clk);
    wrEn = 0; stopCount = 0; maxPos = 5; countMode = 2'b10;
    sawOvf = 0; sawUnf = 0;
    fwdCycle(0);
    checkEq("R9 after overflow", position, 1);
    checkEq("R9 overflow seen", sawOvf, 1);
    bwdCycle(0);
    checkEq("R10 after underflow", position, 3);
    checkEq("R10 underflow seen", sawUnf, 1);

    // R11 stop and write
    wrEn = 1; wrData = 16'h77; @(negedge clk); wrEn = 0; settle();
    checkEq("R11 write while running", position, 3);
    stopCount = 1; wrEn = 1; wrData = 16'h1234; @(negedge clk); wrEn = 0;
    settle();
    checkEq("R11 write while stopped", position, 16'h1234);
    fwdCycle(0);
    checkEq("R11 stopped holds", position, 16'h1234);
    maxPos = 16'hFFFF; stopCount = 0;

    // R7 Z clear
    zGateMode = 0; zSel = 2'b10;
    setPins(0, 0, 1);
    checkEq("R7 rising clear", position, 0);
    setPins(1, 0, 1); setPins(1, 1, 1); setPins(1, 1, 0);
    checkEq("R7 falling ignored", position, 2);
    setPins(0, 1, 1);
    checkEq("R7 clear beats step", position, 0);
    setPins(0, 0, 1);
    checkEq("R7 count after clear", position, 1);
    zSel = 2'b01;
    setPins(0, 0, 0);
    checkEq("R7 falling clear", position, 0);

    // R8 gate
    zGateMode = 1; zSel = 2'b10;
    fwdCycle(0);
    checkEq("R8 gate closed", position, 0);
    setPins(0, 0, 1); fwdCycle(1);
    checkEq("R8 gate open", position, 4);
    zSel = 2'b11;
    fwdCycle(0);
    checkEq("R8 gate disabled", position, 8);

    // R12 direction validity
    countMode = 2'b00; settle();
    countMode = 2'b10; settle();
    checkEq("R12 still invalid", lastDirValid, 0);
    setPins(1, 0, 0);
    checkEq("R12 valid up", {lastDirValid, lastDir}, 3);
    checkEq("R12 position", position, 9);

    running = 0;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule